// File: doc/BRIEF.md
# Debug Probe Processor-Access Register Pair

This block sits between a processor that has issued a load, store or fetch into debug memory and an external JTAG probe that services it. The processor raises a one-cycle request with address, size code, direction and store data. The block latches the request and raises a pending flag. The probe then reads the access through two data registers on the TAP data-register path: an address register and a data register. It uses one shared 32-bit capture/shift/update chain, and a two-bit select code picks which register is active.

The address register can only be read. What it captures is the access address, with its two low bits rebuilt from the size code so that they show which byte lanes are in use. The data register is not storage. A capture returns the store value only while a write is pending; in every other case it returns zero. A word shifted in and updated is kept as load data. That word reaches the processor only when the probe later finishes a pending read. A finish strobe ends the access. For a read, it returns the load word with a one-cycle valid pulse.

Top module: `dbg_pacc_regs`

## Requirements
- R1: While reset is held low, and after it is released, `pending`, `cpu_rvalid` and `tdo` are all 0.
- R2: When `pending` is 0, a `cpu_req` sets `pending` on the next edge, and `pending` stays high until a finish. While `pending` is high, any further `cpu_req` is ignored and the first access is kept.
- R3: With select code 1 (address) and `pending` high, a capture loads `{addr[31:2], lo}`. For size 0 (byte), `lo` is `addr[1:0]`. For size 1 (halfword), `lo` is `{addr[1],0}`. For size 2 (word), `lo` is `00`. For size 3 (three bytes), `lo` is `00` when `addr[1:0]` is 0 and `01` otherwise. Each shift cycle moves the chain one bit toward `tdo`, LSB first, and `tdi` enters at bit 31.
- R4: An address capture while `pending` is 0 returns zero.
- R5: An update with the address selected leaves the access unchanged, so a second capture returns the same address.
- R6: A data capture (select code 2) returns the store data when a write is pending, and zero otherwise. This includes a pending read right after a data update.
- R7: A finish while a read is pending clears `pending`. On the next edge it drives `cpu_rvalid` high for exactly one cycle, with `cpu_rdata` equal to the word from the most recent data update.
- R8: A finish while a write is pending clears `pending` and produces no `cpu_rvalid`.
- R9: With select code 0, capture, shift and update strobes have no effect: `tdo` holds, and the load word is not changed.
- R10: A finish while `pending` is 0 has no effect and produces no `cpu_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor access request strobe |
| cpu_addr | input | 32 | Access address |
| cpu_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 three bytes |
| cpu_wr | input | 1 | 1 for store, 0 for load/fetch |
| cpu_wdata | input | 32 | Store data |
| cpu_rvalid | output | 1 | One-cycle load data valid |
| cpu_rdata | output | 32 | Load/fetch result |
| pending | output | 1 | Access waiting for the probe |
| finish | input | 1 | Finish strobe from the control register |
| tap_sel | input | 2 | Register select: 0 none, 1 address, 2 data |
| tap_capture | input | 1 | Capture-DR strobe |
| tap_shift | input | 1 | Shift-DR enable |
| tap_update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |

## Verification
Each result has a fixed timing:
- `pending` changes one edge after the request or finish that causes it.
- `tdo` shows captured bit 0 one edge after the capture strobe, and the next bit after each further shift edge.
- `cpu_rvalid` and `cpu_rdata` appear one edge after the finish and drop one edge later.

The bench drives every strobe on a falling edge and reads every output on the following falling edge. Each value is therefore read exactly one register stage after the edge that produced it. A full scan collects all 32 captured bits in that way before the update strobe is sent.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    localparam int unsigned PACC_AW = 32;
    localparam int unsigned PACC_DW = 32;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_TRI  = 2'd3
    } acc_size_e;
endpackage

// File: rtl/pacc_lane.sv
module pacc_lane
    import pacc_pkg::*;
#(
    parameter int unsigned AW = PACC_AW
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output logic [AW-1:0] addr_fmt
);
    localparam int unsigned LO_W = 2;

    logic [LO_W-1:0] lo;

    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: lo = addr[LO_W-1:0];
            SZ_HALF: lo = {addr[1], 1'b0};
            SZ_WORD: lo = 2'b00;
            default: lo = {1'b0, |addr[LO_W-1:0]};
        endcase
        addr_fmt = {addr[AW-1:LO_W], lo};
    end
endmodule

// File: rtl/pacc_dr.sv
module pacc_dr #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic         tdo,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic [W-1:0] sr;
    } dr_state_t;

    dr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (capture) begin
            s_d.sr = cap_val;
        end else if (shift) begin
            s_d.sr = {tdi, s_q.sr[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tdo  = s_q.sr[0];
    assign word = s_q.sr;
endmodule

// File: rtl/pacc_hold.sv
module pacc_hold #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr_fmt,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          finish,
    input  logic          upd_data,
    input  logic [DW-1:0] upd_word,
    output logic          pending,
    output logic          pend_wr,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] acc_wdata,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic          pend;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] ld;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } hold_state_t;

    hold_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        if (upd_data) begin
            s_d.ld = upd_word;
        end
        if (!s_q.pend) begin
            if (req) begin
                s_d.pend  = 1'b1;
                s_d.wr    = wr;
                s_d.addr  = addr_fmt;
                s_d.wdata = wdata;
            end
        end else if (finish) begin
            s_d.pend = 1'b0;
            if (!s_q.wr) begin
                s_d.rvalid = 1'b1;
                s_d.rdata  = upd_data ? upd_word : s_q.ld;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pending   = s_q.pend;
    assign pend_wr   = s_q.wr;
    assign acc_addr  = s_q.addr;
    assign acc_wdata = s_q.wdata;
    assign rvalid    = s_q.rvalid;
    assign rdata     = s_q.rdata;
endmodule

// File: rtl/dbg_pacc_regs.sv
module dbg_pacc_regs
    import pacc_pkg::*;
#(
    parameter int unsigned AW = PACC_AW,
    parameter int unsigned DW = PACC_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    input  logic [1:0]    cpu_size,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_rvalid,
    output logic [DW-1:0] cpu_rdata,
    output logic          pending,
    input  logic          finish,
    input  logic [1:0]    tap_sel,
    input  logic          tap_capture,
    input  logic          tap_shift,
    input  logic          tap_update,
    input  logic          tdi,
    output logic          tdo
);
    localparam int unsigned CW = (AW > DW) ? AW : DW;

    logic [AW-1:0] addr_fmt;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata;
    logic          pend_wr;
    logic [CW-1:0] cap_val;
    logic [CW-1:0] chain_word;
    logic          sel_addr, sel_data, sel_any;
    logic          upd_data;

    pacc_lane #(.AW(AW)) u_lane (
        .addr     (cpu_addr),
        .size     (cpu_size),
        .addr_fmt (addr_fmt)
    );

    assign sel_addr = (reg_sel_e'(tap_sel) == SEL_ADDR);
    assign sel_data = (reg_sel_e'(tap_sel) == SEL_DATA);
    assign sel_any  = sel_addr | sel_data;
    assign upd_data = tap_update & sel_data;

    always_comb begin
        cap_val = '0;
        if (sel_addr && pending) begin
            cap_val[AW-1:0] = acc_addr;
        end else if (sel_data && pending && pend_wr) begin
            cap_val[DW-1:0] = acc_wdata;
        end
    end

    pacc_dr #(.W(CW)) u_dr (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (tap_capture & sel_any),
        .shift   (tap_shift & sel_any),
        .tdi     (tdi),
        .cap_val (cap_val),
        .tdo     (tdo),
        .word    (chain_word)
    );

    pacc_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cpu_req),
        .addr_fmt  (addr_fmt),
        .wr        (cpu_wr),
        .wdata     (cpu_wdata),
        .finish    (finish),
        .upd_data  (upd_data),
        .upd_word  (chain_word[DW-1:0]),
        .pending   (pending),
        .pend_wr   (pend_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .rvalid    (cpu_rvalid),
        .rdata     (cpu_rdata)
    );
endmodule

// File: rtl/pacc_regs_chk.sv
module pacc_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req,
    input logic       finish,
    input logic       pending,
    input logic       cpu_rvalid,
    input logic [1:0] tap_sel,
    input logic       tdo
);
    assert_req_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !pending) |=> pending);

    assert_pending_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !finish) |=> pending);

    assert_finish_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && finish) |=> !pending);

    assert_rvalid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);

    assert_rvalid_needs_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(pending && finish));

    assert_unselected_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_sel == 2'd0) |=> $stable(tdo));
endmodule

bind dbg_pacc_regs pacc_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .finish     (finish),
    .pending    (pending),
    .cpu_rvalid (cpu_rvalid),
    .tap_sel    (tap_sel),
    .tdo        (tdo)
);

// File: tb/sim_dbg_pacc_regs.sv
module sim_dbg_pacc_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        pending;
    logic        finish = 1'b0;
    logic [1:0]  tap_sel = '0;
    logic        tap_capture = 1'b0;
    logic        tap_shift = 1'b0;
    logic        tap_update = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;

    int checks = 0;
    int errs = 0;

    always #4 clk = ~clk;

    dbg_pacc_regs u0 (.*);

    // addr, size, wr, data (store data for writes, load word for reads)
    localparam logic [66:0] VEC [0:5] = '{
        {32'hFF20_0203, 2'd0, 1'b0, 32'h1122_3344},
        {32'hFF20_0107, 2'd1, 1'b1, 32'hCAFE_F00D},
        {32'hFF20_0ABE, 2'd2, 1'b0, 32'hDEAD_BEEF},
        {32'hFF20_0011, 2'd3, 1'b1, 32'h0F0F_A5A5},
        {32'hFF20_0010, 2'd3, 1'b0, 32'h8000_0001},
        {32'h1234_5672, 2'd0, 1'b1, 32'h7654_3210}
    };

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [1:0] sz);
        logic [1:0] lo;
        if (sz == 2'd0)      lo = a[1:0];
        else if (sz == 2'd1) lo = {a[1], 1'b0};
        else if (sz == 2'd2) lo = 2'b00;
        else                 lo = (a[1:0] == 2'b00) ? 2'b00 : 2'b01;
        return {a[31:2], lo};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic scan(input logic [1:0] sel, input logic [31:0] din, output logic [31:0] dout);
        @(negedge clk);
        tap_sel = sel;
        tap_capture = 1'b1;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            tap_capture = 1'b0;
            dout[i] = tdo;
            tdi = din[i];
            tap_shift = 1'b1;
        end
        @(negedge clk);
        tap_shift = 1'b0;
        tap_update = 1'b1;
        @(negedge clk);
        tap_update = 1'b0;
        tap_sel = 2'd0;
    endtask

    task automatic request(input logic [31:0] a, input logic [1:0] sz, input logic w, input logic [31:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_size = sz; cpu_wr = w; cpu_wdata = d; cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic do_finish();
        @(negedge clk);
        finish = 1'b1;
        @(negedge clk);
        finish = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errs++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [31:0] a, d;
        logic [1:0]  sz;
        logic        w;

        repeat (3) @(negedge clk);
        chk("R1 pending in reset", {31'd0, pending}, 32'd0);
        chk("R1 rvalid in reset", {31'd0, cpu_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tdo after reset", {31'd0, tdo}, 32'd0);

        // idle: address capture is zero, finish does nothing
        scan(2'd1, 32'hFFFF_FFFF, got);
        chk("R4 idle address capture", got, 32'd0);
        do_finish();
        chk("R10 idle finish rvalid", {31'd0, cpu_rvalid}, 32'd0);
        chk("R10 idle finish pending", {31'd0, pending}, 32'd0);

        // table of accesses
        for (int v = 0; v < 6; v++) begin
            {a, sz, w, d} = VEC[v];
            request(a, sz, w, d);
            chk("R2 pending after request", {31'd0, pending}, 32'd1);
            scan(2'd1, ~a, got);
            chk("R3 address capture", got, exp_addr(a, sz));
            scan(2'd1, 32'h5A5A_5A5A, got);
            chk("R5 address after update", got, exp_addr(a, sz));
            if (w) begin
                scan(2'd2, 32'h0, got);
                chk("R6 store data capture", got, d);
                do_finish();
                chk("R8 write finish rvalid", {31'd0, cpu_rvalid}, 32'd0);
                chk("R8 write finish pending", {31'd0, pending}, 32'd0);
            end else begin
                scan(2'd2, d, got);
                chk("R6 read data capture", got, 32'd0);
                do_finish();
                chk("R7 rvalid", {31'd0, cpu_rvalid}, 32'd1);
                chk("R7 rdata", cpu_rdata, d);
                chk("R7 pending cleared", {31'd0, pending}, 32'd0);
                @(negedge clk);
                chk("R7 rvalid one cycle", {31'd0, cpu_rvalid}, 32'd0);
            end
        end

        // second request while pending is ignored
        request(32'hFF20_0104, 2'd2, 1'b1, 32'hAAAA_0001);
        request(32'hFF20_0333, 2'd0, 1'b1, 32'hBBBB_0002);
        scan(2'd1, 32'h0, got);
        chk("R2 first address kept", got, 32'hFF20_0104);
        scan(2'd2, 32'h0, got);
        chk("R2 first store data kept", got, 32'hAAAA_0001);
        do_finish();

        // readback after data update, and unselected scan ignored
        request(32'hFF20_0200, 2'd2, 1'b0, 32'h0);
        scan(2'd2, 32'h1357_9BDF, got);
        scan(2'd2, 32'h1357_9BDF, got);
        chk("R6 readback after update", got, 32'd0);
        scan(2'd0, 32'h2468_ACE0, got);
        chk("R9 tdo holds unselected", got, {32{1'b1}});
        do_finish();
        chk("R9 load word unchanged", cpu_rdata, 32'h1357_9BDF);
        chk("R7 rvalid after unselected scan", {31'd0, cpu_rvalid}, 32'd1);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule